// File: doc/BRIEF.md
# Write-Busy Toggle Status Generator

This block sits in the read-data path of a byte-wide nonvolatile memory. It reports an internal write cycle in band, on the data bus itself, so no separate ready/busy pin is needed. While a write cycle runs, one status bit of every read flips relative to the previous read. A second status bit returns the complement of the matching bit of the byte being written. All other bits pass the stored byte through. Once the cycle ends, reads return the stored byte unchanged. A host can poll at any time during the cycle without preparing anything first.

The block also decides whether a write request is real. When protection is on and the unlock sequence has not been seen, the request still runs the write-cycle timer for the full cycle time, and reads behave as status polls, but no data is committed. The memory array and the unlock decoder are outside the block. The array supplies `stored_i` and takes the `commit_o` pulse. The decoder supplies `prot_on_i` and `unlock_ok_i`.

The strobes are treated as synchronous active-low inputs sampled on `clk_i`. A read access is any cycle in which both strobes are low. An access is complete in the first cycle where that is no longer true.

Top module: `wbt_status_top`

## Requirements
- R1: `dq_oe_o` is 1 exactly when `ce_n_i` and `oe_n_i` are both 0; while `dq_oe_o` is 0, `dq_o` is all zeros.
- R2: With no write cycle running, an enabled read returns `dq_o == stored_i`.
- R3: A write request (`wr_req_i` = 1 while `busy_o` = 0) raises `busy_o` from the next cycle for exactly `TWC_CYCLES` cycles. If the request was accepted, `commit_o` is 1 for one cycle only, which is the last busy cycle.
- R4: During a write cycle, bit `TOG_BIT` (default 6) reads 0 on the first completed read after the cycle starts, and it is inverted on each later completed read.
- R5: The toggle advances once per completed read access, not once per clock. Bit `TOG_BIT` stays stable while a read is held active for several cycles.
- R6: During a write cycle, bit `POLL_BIT` (default 7) reads as the complement of `wr_poll_bit_i` captured at the request. Every bit other than `TOG_BIT` and `POLL_BIT` reads as `stored_i`.
- R7: After `busy_o` falls, reads return `stored_i` unchanged, and neither status bit toggles.
- R8: A request with `prot_on_i` = 1 and `unlock_ok_i` = 0 is poll-only. It runs the full busy window with R4 and R6 status, and `commit_o` is never 1 for it.
- R9: `wr_req_i` while `busy_o` = 1 is ignored. The busy window length, the captured poll bit, the toggle sequence and the commit decision of the running cycle are unchanged.
- R10: The toggle state restarts at 0 with every new write cycle, whatever its value at the end of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ce_n_i | input | 1 | Chip enable, active low |
| oe_n_i | input | 1 | Output enable, active low |
| wr_req_i | input | 1 | Write request pulse from the write-strobe logic |
| wr_poll_bit_i | input | 1 | Bit POLL_BIT of the byte being written |
| prot_on_i | input | 1 | Write protection is active |
| unlock_ok_i | input | 1 | Unlock sequence preceded this request |
| stored_i | input | DW | Stored byte at the addressed location |
| dq_o | output | DW | Read data, zeros when not driven |
| dq_oe_o | output | 1 | Data bus drive enable |
| busy_o | output | 1 | Write cycle in progress |
| commit_o | output | 1 | One-cycle pulse: array may take the written byte |

## Verification
The bench builds the block with an 8-bit bus, the toggle bit at 6, the polling bit at 7 and `TWC_CYCLES` set to 40 instead of the long default. With the short window, about thirty complete write cycles fit in the run. Each of them carries several reads of random hold length, a stray request in mid-cycle, and a read after the cycle ends. Protected and unprotected requests are mixed, so committing cycles and poll-only cycles both occur, as well as back-to-back restarts that begin with a toggle state of either value.

// File: rtl/wbt_pkg.sv
package wbt_pkg;

    // Outcome of a write request as seen by the write gate
    typedef enum logic [1:0] {
        WR_NONE      = 2'd0,
        WR_COMMIT    = 2'd1,
        WR_POLL_ONLY = 2'd2
    } wr_kind_e;

    // Read-access tracker state
    typedef struct packed {
        logic act;   // a read access was active last cycle
        logic tog;   // current toggle status bit
    } rd_state_t;

endpackage

// File: rtl/wbt_write_gate.sv
module wbt_write_gate
    import wbt_pkg::*;
(
    input  logic     req_i,
    input  logic     busy_i,
    input  logic     prot_on_i,
    input  logic     unlock_ok_i,
    output wr_kind_e kind_o
);

    always_comb begin
        kind_o = WR_NONE;
        if (req_i && !busy_i) begin
            if (prot_on_i && !unlock_ok_i) begin
                kind_o = WR_POLL_ONLY;
            end else begin
                kind_o = WR_COMMIT;
            end
        end
    end

endmodule

// File: rtl/wbt_cycle_timer.sv
module wbt_cycle_timer #(
    parameter int unsigned TWC_CYCLES = 2500
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    input  logic keep_i,
    input  logic poll_bit_i,
    output logic busy_o,
    output logic commit_o,
    output logic poll_inv_o
);

    localparam int unsigned CW = (TWC_CYCLES < 2) ? 1 : $clog2(TWC_CYCLES);

    typedef struct packed {
        logic          busy;
        logic          keep;
        logic          inv;
        logic [CW-1:0] cnt;
    } tmr_state_t;

    tmr_state_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (tmr_q.busy) begin
            if (tmr_q.cnt == '0) begin
                tmr_d.busy = 1'b0;
                tmr_d.keep = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt - 1'b1;
            end
        end
        if (start_i) begin
            tmr_d.busy = 1'b1;
            tmr_d.keep = keep_i;
            tmr_d.inv  = ~poll_bit_i;
            tmr_d.cnt  = CW'(TWC_CYCLES - 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy_o     = tmr_q.busy;
    assign commit_o   = tmr_q.busy && tmr_q.keep && (tmr_q.cnt == '0);
    assign poll_inv_o = tmr_q.inv;

endmodule

// File: rtl/wbt_toggle_track.sv
module wbt_toggle_track
    import wbt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic ce_n_i,
    input  logic oe_n_i,
    input  logic busy_i,
    input  logic restart_i,
    output logic rd_en_o,
    output logic tog_o
);

    rd_state_t rd_d, rd_q;
    logic      rd_now;

    assign rd_now = !ce_n_i && !oe_n_i;

    always_comb begin
        rd_d     = rd_q;
        rd_d.act = rd_now;
        if (restart_i) begin
            rd_d.tog = 1'b0;
        end else if (busy_i && rd_q.act && !rd_now) begin
            rd_d.tog = ~rd_q.tog;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            rd_q <= '0;
        end else begin
            rd_q <= rd_d;
        end
    end

    assign rd_en_o = rd_now;
    assign tog_o   = rd_q.tog;

endmodule

// File: rtl/wbt_dq_mux.sv
module wbt_dq_mux #(
    parameter int unsigned DW       = 8,
    parameter int unsigned TOG_BIT  = 6,
    parameter int unsigned POLL_BIT = 7
) (
    input  logic          rd_en_i,
    input  logic          busy_i,
    input  logic          tog_i,
    input  logic          poll_inv_i,
    input  logic [DW-1:0] stored_i,
    output logic [DW-1:0] dq_o
);

    for (genvar b = 0; b < DW; b++) begin : g_bit
        logic status_v;
        if (b == TOG_BIT) begin : g_tog
            assign status_v = tog_i;
        end else if (b == POLL_BIT) begin : g_poll
            assign status_v = poll_inv_i;
        end else begin : g_pass
            assign status_v = stored_i[b];
        end
        always_comb begin
            if (!rd_en_i) begin
                dq_o[b] = 1'b0;
            end else if (busy_i) begin
                dq_o[b] = status_v;
            end else begin
                dq_o[b] = stored_i[b];
            end
        end
    end

endmodule

// File: rtl/wbt_status_top.sv
module wbt_status_top
    import wbt_pkg::*;
#(
    parameter int unsigned DW         = 8,
    parameter int unsigned TOG_BIT    = 6,
    parameter int unsigned POLL_BIT   = 7,
    parameter int unsigned TWC_CYCLES = 2500
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          ce_n_i,
    input  logic          oe_n_i,
    input  logic          wr_req_i,
    input  logic          wr_poll_bit_i,
    input  logic          prot_on_i,
    input  logic          unlock_ok_i,
    input  logic [DW-1:0] stored_i,
    output logic [DW-1:0] dq_o,
    output logic          dq_oe_o,
    output logic          busy_o,
    output logic          commit_o
);

    wr_kind_e kind;
    logic     start;
    logic     busy;
    logic     tog;
    logic     poll_inv;
    logic     rd_en;

    assign start = (kind != WR_NONE);

    wbt_write_gate u_gate (
        .req_i       (wr_req_i),
        .busy_i      (busy),
        .prot_on_i   (prot_on_i),
        .unlock_ok_i (unlock_ok_i),
        .kind_o      (kind)
    );

    wbt_cycle_timer #(
        .TWC_CYCLES (TWC_CYCLES)
    ) u_timer (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (start),
        .keep_i     (kind == WR_COMMIT),
        .poll_bit_i (wr_poll_bit_i),
        .busy_o     (busy),
        .commit_o   (commit_o),
        .poll_inv_o (poll_inv)
    );

    wbt_toggle_track u_track (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .ce_n_i    (ce_n_i),
        .oe_n_i    (oe_n_i),
        .busy_i    (busy),
        .restart_i (start),
        .rd_en_o   (rd_en),
        .tog_o     (tog)
    );

    wbt_dq_mux #(
        .DW       (DW),
        .TOG_BIT  (TOG_BIT),
        .POLL_BIT (POLL_BIT)
    ) u_mux (
        .rd_en_i    (rd_en),
        .busy_i     (busy),
        .tog_i      (tog),
        .poll_inv_i (poll_inv),
        .stored_i   (stored_i),
        .dq_o       (dq_o)
    );

    assign dq_oe_o = rd_en;
    assign busy_o  = busy;

endmodule

// File: rtl/wbt_status_checker.sv
module wbt_status_checker #(
    parameter int unsigned DW         = 8,
    parameter int unsigned TOG_BIT    = 6,
    parameter int unsigned POLL_BIT   = 7,
    parameter int unsigned TWC_CYCLES = 2500
) (
    input logic          clk_i,
    input logic          rst_ni,
    input logic          ce_n_i,
    input logic          oe_n_i,
    input logic          wr_req_i,
    input logic          wr_poll_bit_i,
    input logic          prot_on_i,
    input logic          unlock_ok_i,
    input logic [DW-1:0] stored_i,
    input logic [DW-1:0] dq_o,
    input logic          dq_oe_o,
    input logic          busy_o,
    input logic          commit_o
);

    logic        chk_start;
    logic        chk_ok_q;
    logic        chk_inv_q;
    logic [31:0] chk_run_q;

    assign chk_start = wr_req_i && !busy_o;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chk_ok_q  <= 1'b0;
            chk_inv_q <= 1'b0;
            chk_run_q <= '0;
        end else if (chk_start) begin
            chk_ok_q  <= !(prot_on_i && !unlock_ok_i);
            chk_inv_q <= ~wr_poll_bit_i;
            chk_run_q <= '0;
        end else if (busy_o) begin
            chk_run_q <= chk_run_q + 1;
        end
    end

    p_float_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dq_oe_o |-> dq_o == '0);

    p_enable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (ce_n_i || oe_n_i) |-> !dq_oe_o);

    p_idle_pass_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && dq_oe_o) |-> dq_o == stored_i);

    p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chk_start |=> busy_o);

    p_len_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |-> (busy_o && chk_run_q == TWC_CYCLES - 1));

    p_commit_end_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |=> !busy_o);

    p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && dq_oe_o && $past(dq_oe_o))
            |-> $stable(dq_o[TOG_BIT]));

    p_poll_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && dq_oe_o) |-> dq_o[POLL_BIT] == chk_inv_q);

    p_nocommit_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        commit_o |-> chk_ok_q);

endmodule

bind wbt_status_top wbt_status_checker #(
    .DW         (DW),
    .TOG_BIT    (TOG_BIT),
    .POLL_BIT   (POLL_BIT),
    .TWC_CYCLES (TWC_CYCLES)
) u_checker (.*);

// File: tb/wbt_status_top_tb_top.sv
module wbt_status_top_tb_top;

    localparam int unsigned DW  = 8;
    localparam int unsigned TB  = 6;
    localparam int unsigned PB  = 7;
    localparam int unsigned TWC = 40;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          oe_n = 1'b1;
    logic          wr_req = 1'b0;
    logic          wr_pb = 1'b0;
    logic          prot_on = 1'b0;
    logic          unlock_ok = 1'b0;
    logic [DW-1:0] stored = '0;
    logic [DW-1:0] dq;
    logic          dq_oe;
    logic          busy;
    logic          commit;

    int n_cmp = 0;
    int n_bad = 0;
    int busy_cyc = 0;
    int n_commit = 0;
    int commit_at = -1;
    logic exp_tog;
    logic exp_inv;

    always #2 clk = ~clk;

    wbt_status_top #(
        .DW (DW), .TOG_BIT (TB), .POLL_BIT (PB), .TWC_CYCLES (TWC)
    ) dut_i (
        .clk_i (clk), .rst_ni (rst_n), .ce_n_i (ce_n), .oe_n_i (oe_n),
        .wr_req_i (wr_req), .wr_poll_bit_i (wr_pb), .prot_on_i (prot_on),
        .unlock_ok_i (unlock_ok), .stored_i (stored), .dq_o (dq),
        .dq_oe_o (dq_oe), .busy_o (busy), .commit_o (commit)
    );

    always @(negedge clk) begin
        if (busy) busy_cyc = busy_cyc + 1;
        if (commit) begin
            n_commit  = n_commit + 1;
            commit_at = busy_cyc;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] exp_dq(input logic [DW-1:0] st, input logic bz,
                                              input logic tg, input logic inv);
        logic [DW-1:0] r;
        r = st;
        if (bz) begin
            r[TB] = tg;
            r[PB] = inv;
        end
        return r;
    endfunction

    // One read access held for 'hold' cycles; checks every held cycle
    task automatic do_read(input int hold, input logic bz);
        @(negedge clk);
        ce_n = 1'b0;
        oe_n = 1'b0;
        for (int i = 0; i < hold; i++) begin
            stored = DW'($urandom);
            #1;
            chk("R1 enable", {31'd0, dq_oe}, 32'd1);
            if (bz) chk("R4/R5/R6 busy read", {24'd0, dq}, {24'd0, exp_dq(stored, 1'b1, exp_tog, exp_inv)});
            else    chk("R2/R7 idle read", {24'd0, dq}, {24'd0, stored});
            if (i + 1 < hold) @(negedge clk);
        end
        @(negedge clk);
        if ($urandom_range(0, 1) == 0) ce_n = 1'b1; else oe_n = 1'b1;
        #1;
        chk("R1 float", {31'd0, dq_oe, dq}, 32'd0);
        @(negedge clk);
        ce_n = 1'b1;
        oe_n = 1'b1;
        if (bz) exp_tog = ~exp_tog;
    endtask

    task automatic do_write(input logic pbit, input logic prot, input logic unl, input bit poke);
        logic acc;
        acc = !(prot && !unl);
        @(negedge clk);
        busy_cyc = 0;
        n_commit = 0;
        commit_at = -1;
        wr_req = 1'b1; wr_pb = pbit; prot_on = prot; unlock_ok = unl;
        @(negedge clk);
        wr_req = 1'b0;
        exp_tog = 1'b0;   // R10 restart
        exp_inv = ~pbit;
        #1;
        chk("R3 busy rises", {31'd0, busy}, 32'd1);
        for (int k = 0; k < 12; k++) begin
            int h;
            h = $urandom_range(1, 4);
            if (busy_cyc + h + 6 >= TWC) break;
            if (poke && k == 1) begin
                // R9: stray request during busy
                @(negedge clk);
                wr_req = 1'b1; wr_pb = ~pbit; prot_on = 1'b0; unlock_ok = 1'b1;
                @(negedge clk);
                wr_req = 1'b0;
            end
            do_read(h, 1'b1);
        end
        while (busy) @(negedge clk);
        #1;
        chk("R3/R9 busy length", busy_cyc, TWC);
        chk("R3/R8/R9 commit count", n_commit, acc ? 1 : 0);
        if (acc) chk("R3 commit in last busy cycle", commit_at, TWC);
        do_read($urandom_range(1, 3), 1'b0);   // R7
    endtask

    initial begin
        process p;
        p = process::self();
        p.srandom(32'h5EED_0042);
        exp_tog = 1'b0;
        exp_inv = 1'b0;
        repeat (4) @(negedge clk);
        #1;
        chk("R1 reset float", {31'd0, dq_oe, dq}, 32'd0);
        chk("R3 reset idle", {30'd0, busy, commit}, 32'd0);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) do_read($urandom_range(1, 3), 1'b0);  // R2
        // Directed: accepted write, long hold read for R5
        do_write(1'b1, 1'b0, 1'b0, 1'b0);
        // Directed: poll-only write with stray request (R8, R9)
        do_write(1'b0, 1'b1, 1'b0, 1'b1);
        // Directed: unlocked protected write
        do_write(1'b1, 1'b1, 1'b1, 1'b1);
        // Random mix, back to back restarts (R10)
        for (int n = 0; n < 30; n++) begin
            do_write(1'($urandom), 1'($urandom), 1'($urandom), ($urandom_range(0, 2) == 0));
        end
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule